// File: doc/BRIEF.md
# ROM Bank Chip-Select Controller

This block sits between a CPU bus and up to four ROM or flash banks. On each CPU request it compares the address with each bank's programmed window and picks one bank. It then runs the external bus cycles for that bank: an address-latch pulse, a strobe phase whose length is set by a programmable wait count, and a per-bank active-low chip select. It answers the CPU with a one-cycle ready pulse.

Each bank has its own data path width of 8, 16 or 32 bits. A 32-bit CPU read from a narrow bank becomes a series of narrow ROM cycles: four byte cycles or two halfword cycles. The returned lanes are assembled little-endian into one 32-bit word. A write is always a single ROM cycle. All configuration (bank windows, width codes, wait count) arrives on plain input ports. The configuration is held stable while a request is in flight.

Top module: `rom_cs_ctrl`

## Requirements
- R1: A bank matches when width code != 11 and base <= cpu_addr < base + size. During that access only the matched bank's rom_cs_n bit is low. The chip select is low through the ALE cycle and every strobe cycle of every beat.
- R2: When several banks match, the lowest-numbered bank is selected.
- R3: Bank i's width code is width_cfg[2i+1:2i], with 00 = 8-bit, 01 = 16-bit, 10 = 32-bit and 11 = disabled. A disabled bank never drives its chip select and is skipped during matching.
- R4: A read from an 8-bit bank runs four beats. Beat k drives rom_addr = {cpu_addr[top:2], k}. It takes rom_rdata[7:0] into cpu_rdata[8k+7:8k].
- R5: A read from a 16-bit bank runs two beats. Beat k drives rom_addr low bits = {k,0}. It takes rom_rdata[15:0] into cpu_rdata[16k+15:16k].
- R6: A read from a 32-bit bank runs one beat with rom_addr low bits 00. It returns rom_rdata unchanged.
- R7: Each beat is one cycle with rom_ale high, followed by wait_cfg+1 strobe cycles. The request is accepted at the clock edge where cpu_req is high and the block is idle. cpu_ready is then high in cycle beats*(wait_cfg+2)+1 after that edge.
- R8: rom_oe_n is low only during read strobe cycles. At those times rom_rw_n is high, rom_ale is low and a chip select is active. At most one chip select is low at any time.
- R9: A write runs one beat at cpu_addr. rom_rw_n is low, rom_oe_n stays high and rom_wdata equals cpu_wdata.
- R10: A request that matches no bank drives no ROM cycle. cpu_ready rises in cycle 1 after acceptance, with cpu_rdata = 0.
- R11: After reset all chip selects, rom_oe_n and rom_rw_n are high, and rom_ale and cpu_ready are low.
- R12: cpu_ready is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | CPU byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Assembled read data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| bank_base | input | 4*ADDR_W | Bank base addresses, bank i at slice i |
| bank_size | input | 4*ADDR_W | Bank window sizes in bytes |
| width_cfg | input | 8 | Two-bit width code per bank |
| wait_cfg | input | WAIT_W | Extra strobe cycles per beat |
| rom_cs_n | output | 4 | Active-low bank chip selects |
| rom_oe_n | output | 1 | Active-low output enable |
| rom_rw_n | output | 1 | High = read, low = write |
| rom_ale | output | 1 | Address latch enable |
| rom_addr | output | ADDR_W | ROM byte address for the current beat |
| rom_wdata | output | 32 | ROM write data |
| rom_rdata | input | 32 | ROM read data |

## Verification
The bound checker watches the bus-level rules on every cycle. These rules are:
- at most one chip select is active;
- a disabled bank is never selected;
- output enable appears only on read strobes, never together with ALE;
- ALE and ready each last a single cycle.

Only the bench's scenarios can show which bank wins in an overlap, the address sequence of each beat, the lane packing, the exact latency for each wait count, and the miss response. The bench sweeps every wait count from 0 to 3 over addresses at window edges, in two width configurations, and computes each expected value arithmetically.

// File: rtl/rom_cs_pkg.sv
package rom_cs_pkg;
    localparam int NB    = 4;
    localparam int IDX_W = $clog2(NB);
    localparam int DW    = 32;

    typedef enum logic [1:0] {
        BW8   = 2'b00,
        BW16  = 2'b01,
        BW32  = 2'b10,
        BWOFF = 2'b11
    } bus_w_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_LATCH,
        S_STROBE,
        S_DONE
    } seq_st_e;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] bank;
        bus_w_e           width;
    } dec_res_t;

    function automatic logic [1:0] last_beat(bus_w_e w);
        case (w)
            BW8:     return 2'd3;
            BW16:    return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic [1:0] low_bits(bus_w_e w, logic [1:0] beat);
        case (w)
            BW8:     return beat;
            BW16:    return {beat[0], 1'b0};
            default: return 2'b00;
        endcase
    endfunction
endpackage

// File: rtl/rom_bank_decode.sv
module rom_bank_decode
    import rom_cs_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NB*ADDR_W-1:0] base_flat,
    input  logic [NB*ADDR_W-1:0] size_flat,
    input  logic [2*NB-1:0]      width_cfg,
    output dec_res_t             res
);
    logic [NB-1:0] match;

    generate
        for (genvar g = 0; g < NB; g++) begin : g_bank
            logic [ADDR_W-1:0] b_base, b_size, b_off;
            assign b_base   = base_flat[g*ADDR_W +: ADDR_W];
            assign b_size   = size_flat[g*ADDR_W +: ADDR_W];
            assign b_off    = addr - b_base;
            assign match[g] = (addr >= b_base) && (b_off < b_size) &&
                              (bus_w_e'(width_cfg[2*g +: 2]) != BWOFF);
        end
    endgenerate

    // lowest index wins: scan downward so the last assignment is the lowest
    always_comb begin
        res.hit   = 1'b0;
        res.bank  = '0;
        res.width = BW8;
        for (int i = NB - 1; i >= 0; i--) begin
            if (match[i]) begin
                res.hit   = 1'b1;
                res.bank  = IDX_W'(i);
                res.width = bus_w_e'(width_cfg[2*i +: 2]);
            end
        end
    end
endmodule

// File: rtl/rom_beat_seq.sv
module rom_beat_seq
    import rom_cs_pkg::*;
#(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              we,
    input  dec_res_t          dec,
    input  logic [WAIT_W-1:0] wait_cfg,
    output seq_st_e           st,
    output dec_res_t          ctx,
    output logic              we_q,
    output logic [1:0]        beat,
    output logic              accept,
    output logic              cap
);
    logic [WAIT_W-1:0] wcnt;
    logic [1:0]        lastb;
    logic              wait_end;

    assign lastb    = we_q ? 2'd0 : last_beat(ctx.width);
    assign wait_end = (wcnt == wait_cfg);
    assign accept   = (st == S_IDLE) && req;
    assign cap      = (st == S_STROBE) && wait_end && !we_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= S_IDLE;
            ctx  <= '0;
            we_q <= 1'b0;
            beat <= 2'd0;
            wcnt <= '0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (req) begin
                        ctx  <= dec;
                        we_q <= we;
                        beat <= 2'd0;
                        wcnt <= '0;
                        st   <= dec.hit ? S_LATCH : S_DONE;
                    end
                end
                S_LATCH: begin
                    wcnt <= '0;
                    st   <= S_STROBE;
                end
                S_STROBE: begin
                    if (wait_end) begin
                        if (beat == lastb) begin
                            st <= S_DONE;
                        end else begin
                            beat <= beat + 2'd1;
                            st   <= S_LATCH;
                        end
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rom_read_pack.sv
module rom_read_pack
    import rom_cs_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          cap,
    input  logic [1:0]    beat,
    input  bus_w_e        width,
    input  logic [DW-1:0] rd,
    output logic [DW-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            data <= '0;
        end else if (cap) begin
            case (width)
                BW8:     data[8*beat +: 8]      <= rd[7:0];
                BW16:    data[16*beat[0] +: 16] <= rd[15:0];
                default: data                   <= rd;
            endcase
        end
    end
endmodule

// File: rtl/rom_cs_ctrl.sv
module rom_cs_ctrl
    import rom_cs_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int WAIT_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cpu_req,
    input  logic                 cpu_we,
    input  logic [ADDR_W-1:0]    cpu_addr,
    input  logic [DW-1:0]        cpu_wdata,
    output logic [DW-1:0]        cpu_rdata,
    output logic                 cpu_ready,
    input  logic [NB*ADDR_W-1:0] bank_base,
    input  logic [NB*ADDR_W-1:0] bank_size,
    input  logic [2*NB-1:0]      width_cfg,
    input  logic [WAIT_W-1:0]    wait_cfg,
    output logic [NB-1:0]        rom_cs_n,
    output logic                 rom_oe_n,
    output logic                 rom_rw_n,
    output logic                 rom_ale,
    output logic [ADDR_W-1:0]    rom_addr,
    output logic [DW-1:0]        rom_wdata,
    input  logic [DW-1:0]        rom_rdata
);
    dec_res_t          dec, ctx;
    seq_st_e           st;
    logic              we_q, accept, cap, busy;
    logic [1:0]        beat;
    logic [ADDR_W-1:0] addr_q;
    logic [DW-1:0]     wdata_q;

    rom_bank_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr(cpu_addr), .base_flat(bank_base), .size_flat(bank_size),
        .width_cfg(width_cfg), .res(dec)
    );

    rom_beat_seq #(.WAIT_W(WAIT_W)) u_seq (
        .clk(clk), .rst(rst), .req(cpu_req), .we(cpu_we), .dec(dec),
        .wait_cfg(wait_cfg), .st(st), .ctx(ctx), .we_q(we_q), .beat(beat),
        .accept(accept), .cap(cap)
    );

    rom_read_pack u_pack (
        .clk(clk), .rst(rst), .clr(accept), .cap(cap), .beat(beat),
        .width(ctx.width), .rd(rom_rdata), .data(cpu_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= cpu_addr;
            wdata_q <= cpu_wdata;
        end
    end

    assign busy = (st == S_LATCH) || (st == S_STROBE);

    generate
        for (genvar g = 0; g < NB; g++) begin : g_cs
            assign rom_cs_n[g] = !(busy && (ctx.bank == IDX_W'(g)));
        end
    endgenerate

    assign rom_ale   = (st == S_LATCH);
    assign rom_oe_n  = !((st == S_STROBE) && !we_q);
    assign rom_rw_n  = !(busy && we_q);
    assign rom_addr  = we_q ? addr_q
                            : {addr_q[ADDR_W-1:2], low_bits(ctx.width, beat)};
    assign rom_wdata = wdata_q;
    assign cpu_ready = (st == S_DONE);
endmodule

// File: rtl/rom_cs_chk.sv
module rom_cs_chk
    import rom_cs_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [NB-1:0]   rom_cs_n,
    input logic            rom_oe_n,
    input logic            rom_rw_n,
    input logic            rom_ale,
    input logic            cpu_ready,
    input logic [2*NB-1:0] width_cfg
);
    // R8
    cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~rom_cs_n));

    // R8
    oe_read_only_chk: assert property (@(posedge clk) disable iff (rst)
        !rom_oe_n |-> (rom_rw_n && !rom_ale && (rom_cs_n != '1)));

    // R7
    ale_single_chk: assert property (@(posedge clk) disable iff (rst)
        rom_ale |=> !rom_ale);

    // R12
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !cpu_ready);

    // R10
    ready_idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> (rom_cs_n == '1 && rom_oe_n && rom_rw_n));

    generate
        for (genvar g = 0; g < NB; g++) begin : g_off
            // R3
            disabled_bank_chk: assert property (@(posedge clk) disable iff (rst)
                !rom_cs_n[g] |-> (width_cfg[2*g +: 2] != 2'b11));
        end
    endgenerate
endmodule

bind rom_cs_ctrl rom_cs_chk u_chk (
    .clk(clk), .rst(rst), .rom_cs_n(rom_cs_n), .rom_oe_n(rom_oe_n),
    .rom_rw_n(rom_rw_n), .rom_ale(rom_ale), .cpu_ready(cpu_ready),
    .width_cfg(width_cfg)
);

// File: tb/sim_rom_cs_ctrl.sv
module sim_rom_cs_ctrl;
    localparam int AW = 24;
    localparam int WW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [31:0]   cpu_wdata = '0, cpu_rdata, rom_wdata, rom_rdata;
    logic          cpu_ready, rom_oe_n, rom_rw_n, rom_ale;
    logic [4*AW-1:0] bank_base, bank_size;
    logic [7:0]    width_cfg = 8'hE4;
    logic [WW-1:0] wait_cfg = '0;
    logic [3:0]    rom_cs_n;
    logic [AW-1:0] rom_addr;

    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    function automatic logic [31:0] rom_fn(logic [AW-1:0] x);
        return {x[7:0] ^ 8'hC3, x[15:8], x[7:0] + 8'h29, x[7:0] ^ 8'h96};
    endfunction
    assign rom_rdata = rom_fn(rom_addr);

    assign bank_base = {24'h005000, 24'h004000, 24'h001800, 24'h001000};
    assign bank_size = {24'h000100, 24'h000100, 24'h001000, 24'h001000};

    rom_cs_ctrl u0 (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready), .bank_base(bank_base), .bank_size(bank_size),
        .width_cfg(width_cfg), .wait_cfg(wait_cfg), .rom_cs_n(rom_cs_n),
        .rom_oe_n(rom_oe_n), .rom_rw_n(rom_rw_n), .rom_ale(rom_ale),
        .rom_addr(rom_addr), .rom_wdata(rom_wdata), .rom_rdata(rom_rdata)
    );

    task automatic chk(input logic ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic int exp_bank(logic [AW-1:0] a);
        for (int i = 0; i < 4; i++) begin
            logic [AW-1:0] b, s;
            b = bank_base[i*AW +: AW];
            s = bank_size[i*AW +: AW];
            if (width_cfg[2*i +: 2] != 2'b11 && a >= b && (a - b) < s) return i;
        end
        return -1;
    endfunction

    task automatic run(input logic [AW-1:0] a, input logic w, input logic [31:0] wd,
                       input int wt);
        int eb, beats, cyc, ales, strobes, lat;
        logic [1:0]  wc;
        logic [31:0] exp_d, got;
        logic        done;
        eb = exp_bank(a);
        wc = (eb >= 0) ? width_cfg[2*eb +: 2] : 2'b10;
        beats = (eb < 0) ? 0 : (w ? 1 : (wc == 2'b00 ? 4 : (wc == 2'b01 ? 2 : 1)));
        wait_cfg = WW'(wt);
        cpu_addr = a; cpu_we = w; cpu_wdata = wd; cpu_req = 1'b1;
        cyc = 0; ales = 0; strobes = 0; lat = 0; done = 1'b0;
        exp_d = '0; got = '0;
        while (!done && cyc < 300) begin
            @(negedge clk);
            cyc++;
            if (rom_ale) begin
                logic [AW-1:0] ea;
                if (w) ea = a;
                else if (wc == 2'b00) ea = {a[AW-1:2], 2'(ales)};
                else if (wc == 2'b01) ea = {a[AW-1:2], 1'(ales), 1'b0};
                else ea = {a[AW-1:2], 2'b00};
                // R4 R5 R6 beat address
                chk(rom_addr == ea, "R4/R5/R6 beat address", 32'(rom_addr), 32'(ea));
                // R1 R2 selected bank
                chk(eb >= 0 && rom_cs_n == ~(4'b1 << eb), "R1 R2 chip select",
                    32'(rom_cs_n), 32'(eb >= 0 ? ~(4'b1 << eb) : 4'hF));
                if (!w) begin
                    if (wc == 2'b00) exp_d[8*ales +: 8] = rom_fn(ea)[7:0];
                    else if (wc == 2'b01) exp_d[16*ales +: 16] = rom_fn(ea)[15:0];
                    else exp_d = rom_fn(ea);
                end
                ales++;
            end else if (rom_cs_n != 4'hF) begin
                strobes++;
                if (w) begin
                    // R9 write strobe
                    chk(!rom_rw_n && rom_oe_n && rom_wdata == wd, "R9 write strobe",
                        rom_wdata, wd);
                end else begin
                    chk(!rom_oe_n, "R8 read strobe oe", 32'(rom_oe_n), 32'd0);
                end
            end
            if (cpu_ready) begin
                got = cpu_rdata; lat = cyc; done = 1'b1;
            end
        end
        cpu_req = 1'b0;
        chk(done, "R7 ready seen", 32'(done), 32'd1);
        chk(ales == beats, "R4/R5/R6 beat count", 32'(ales), 32'(beats));
        chk(strobes == beats * (wt + 1), "R7 strobe cycles", 32'(strobes),
            32'(beats * (wt + 1)));
        if (eb < 0) begin
            chk(lat == 1, "R10 miss latency", 32'(lat), 32'd1);
            chk(got == 0, "R10 miss data", got, 32'd0);
        end else begin
            chk(lat == beats * (wt + 2) + 1, "R7 latency", 32'(lat),
                32'(beats * (wt + 2) + 1));
            if (!w) chk(got == exp_d, "R4/R5/R6 read data", got, exp_d);
        end
        @(negedge clk);
        chk(!cpu_ready, "R12 ready one cycle", 32'(cpu_ready), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [AW-1:0] addrs [12];
        addrs = '{24'h001004, 24'h0017FD, 24'h001800, 24'h001FFE, 24'h002000,
                  24'h0027FC, 24'h002800, 24'h004000, 24'h0040FC, 24'h004100,
                  24'h005000, 24'h000FFC};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(rom_cs_n == 4'hF && rom_oe_n && rom_rw_n && !rom_ale && !cpu_ready,
            "R11 reset outputs", {rom_cs_n, rom_oe_n, rom_rw_n, rom_ale, cpu_ready},
            {4'hF, 1'b1, 1'b1, 1'b0, 1'b0});
        for (int cfg = 0; cfg < 2; cfg++) begin
            // cfg 1 disables bank 0 (R3): its window falls to bank 1 or misses
            width_cfg = (cfg == 0) ? 8'hE4 : 8'hE7;
            for (int wt = 0; wt < 4; wt++) begin
                for (int i = 0; i < 12; i++) run(addrs[i], 1'b0, 32'h0, wt);
                for (int i = 0; i < 12; i += 3)
                    run(addrs[i], 1'b1, 32'hA5000000 + 32'(i * 4099 + wt), wt);
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule